// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This unit treats each 64-bit operand as a row of independent integer lanes and applies one arithmetic or comparison operation to every lane at once. The caller picks the lane size (8, 16, 32 or 64 bits) and the operation. The operations are:

- add or subtract with wraparound;
- add or subtract with signed or unsigned clamping;
- unsigned rounding average;
- lane-wise equality or signed greater-than, which produces a mask.

A carry or borrow never passes from one lane into the next.

The operands, lane size and operation are presented together with `in_valid`. One clock later the registered result appears with `out_valid`. If a lane size and operation pair is not supported, the result is forced to zero and `out_illegal` is raised for that cycle. The unit is meant to sit in one execute stage of a media datapath.

Top module: `pk_addsub_alu`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle with `in_valid` high. A rising clock edge with `rst_n` low clears `out_valid`, `out_data` and `out_illegal`, even if `in_valid` is high at that edge.
- R2: Operation code 0 adds each lane of A to the matching lane of B modulo 2^width. It is legal for lane codes 0 (8-bit), 1 (16-bit), 2 (32-bit) and 3 (one 64-bit lane). No carry crosses a lane boundary.
- R3: Operation code 1 computes A minus B per lane modulo 2^width, for all four lane codes.
- R4: Operation codes 2 (add) and 3 (A minus B) treat lanes as two's complement. A result above the lane maximum becomes 0x7F..F, and a result below the minimum becomes 0x80..0. These codes are legal for lane codes 0 and 1 only.
- R5: Operation codes 4 (add) and 5 (A minus B) treat lanes as unsigned. A sum that overflows becomes all ones, and a difference below zero becomes zero. These codes are legal for lane codes 0 and 1 only.
- R6: Operation code 6 writes (A+B+1)>>1 per lane, computed unsigned without losing the carry. It is legal for lane codes 0 and 1 only.
- R7: Operation code 7 writes all ones into a lane whose A and B are equal, and all zeros otherwise. It is legal for lane codes 0, 1 and 2.
- R8: Operation code 8 writes all ones into a lane where A is greater than B as signed numbers, and all zeros otherwise. It is legal for lane codes 0, 1 and 2.
- R9: Any other pairing is illegal. This covers codes 2 to 6 with lane code 2 or 3, codes 7 and 8 with lane code 3, and codes 9 to 15 with any lane. An illegal pairing with `in_valid` high yields `out_data` of zero and `out_illegal` high in the result cycle.
- R10: After a clock with `in_valid` low, `out_data` keeps its previous value and `out_illegal` is low, whatever A, B, lane or operation code are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and codes are present this cycle |
| lane_sel | input | 2 | Lane size code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| op_sel | input | 4 | Operation code, 0 to 8 defined |
| opnd_a | input | 64 | First operand, packed lanes, lane 0 in the low bits |
| opnd_b | input | 64 | Second operand, same packing |
| out_valid | output | 1 | Result register holds a new result |
| out_data | output | 64 | Registered packed result |
| out_illegal | output | 1 | The captured pairing was unsupported |

## Verification
Within one operation, a clamp in one lane and ordinary arithmetic in the lane beside it happen in the same cycle. The same holds for a lane that wraps and a neighbour that must not see its carry. The vectors set up exactly these cases: a byte that overflows sits next to a byte that does not, and a halfword that reaches all ones sits next to a zero. Each lane of the registered result is then judged against its own hand-computed value. The same operand bits are also presented at different lane sizes, which separates a lane boundary from a carry that should propagate.

// File: rtl/pk_alu_pkg.sv
// Package: codes shared by the packed add/subtract unit and its checker.
// Assumes lane code 3 means a single lane covering the whole data word.
package pk_alu_pkg;

    typedef enum logic [1:0] {
        LW_8  = 2'd0,
        LW_16 = 2'd1,
        LW_32 = 2'd2,
        LW_64 = 2'd3
    } lane_w_e;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_ADDS  = 4'd2,
        OP_SUBS  = 4'd3,
        OP_ADDU  = 4'd4,
        OP_SUBU  = 4'd5,
        OP_AVG   = 4'd6,
        OP_CMPEQ = 4'd7,
        OP_CMPGT = 4'd8
    } op_e;

    localparam int NUM_WIDTHS = 4;
    localparam int MIN_LANE_W = 8;

endpackage

// File: rtl/pk_lane.sv
// Module: one lane of width W. Computes the selected operation on a and b.
// Assumes op_sel carries a code from pk_alu_pkg::op_e; unknown codes give zero.
// Purely combinational. Legality is decided elsewhere.
module pk_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   op_sel,
    output logic [W-1:0] y
);
    import pk_alu_pkg::*;

    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   sum_x;
    logic [W:0]   dif_x;
    logic [W+1:0] avg_x;
    logic         s_ovf_add;
    logic         s_ovf_sub;

    // Extended sum, difference and rounded sum, so carries and borrows are kept.
    assign sum_x = {1'b0, a} + {1'b0, b};
    assign dif_x = {1'b0, a} - {1'b0, b};
    assign avg_x = {2'b00, a} + {2'b00, b} + {{(W+1){1'b0}}, 1'b1};

    // Signed overflow: the result sign disagrees with what the operand signs allow.
    assign s_ovf_add = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
    assign s_ovf_sub = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);

    // Pick the lane result for the requested operation.
    always_comb begin
        unique case (op_sel)
            OP_ADD:   y = sum_x[W-1:0];
            OP_SUB:   y = dif_x[W-1:0];
            OP_ADDS:  y = s_ovf_add ? (a[W-1] ? SMIN : SMAX) : sum_x[W-1:0];
            OP_SUBS:  y = s_ovf_sub ? (a[W-1] ? SMIN : SMAX) : dif_x[W-1:0];
            OP_ADDU:  y = sum_x[W] ? {W{1'b1}} : sum_x[W-1:0];
            OP_SUBU:  y = dif_x[W] ? {W{1'b0}} : dif_x[W-1:0];
            OP_AVG:   y = avg_x[W:1];
            OP_CMPEQ: y = (a == b) ? {W{1'b1}} : {W{1'b0}};
            OP_CMPGT: y = ($signed(a) > $signed(b)) ? {W{1'b1}} : {W{1'b0}};
            default:  y = {W{1'b0}};
        endcase
    end

endmodule

// File: rtl/pk_legal.sv
// Module: decides whether a lane size and operation pairing is supported.
// Assumes the codes from pk_alu_pkg. Purely combinational.
module pk_legal (
    input  logic [1:0] lane_sel,
    input  logic [3:0] op_sel,
    output logic       legal
);
    import pk_alu_pkg::*;

    // Wraparound works at all sizes; clamp and average need 8/16; compares need up to 32.
    always_comb begin
        unique case (op_sel)
            OP_ADD, OP_SUB:                  legal = 1'b1;
            OP_ADDS, OP_SUBS, OP_ADDU,
            OP_SUBU, OP_AVG:                 legal = (lane_sel == LW_8) || (lane_sel == LW_16);
            OP_CMPEQ, OP_CMPGT:              legal = (lane_sel != LW_64);
            default:                         legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/pk_addsub_alu.sv
// Module: packed add/subtract/average/compare unit with one register stage.
// Every lane size is computed in parallel and the requested one is selected.
// Assumes DATA_W is a multiple of the largest lane (8 << (NUM_WIDTHS-1)).
// Synchronous active-low reset.
module pk_addsub_alu #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        lane_sel,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_illegal
);
    import pk_alu_pkg::*;

    logic [NUM_WIDTHS-1:0][DATA_W-1:0] res_w;
    logic [DATA_W-1:0]                 res_sel;
    logic                              legal;

    // One lane bank per lane size; each bank splits the word into equal lanes.
    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
        localparam int LW = MIN_LANE_W << g;
        localparam int NL = DATA_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            pk_lane #(.W(LW)) u_lane (
                .a      (opnd_a[l*LW +: LW]),
                .b      (opnd_b[l*LW +: LW]),
                .op_sel (op_sel),
                .y      (res_w[g][l*LW +: LW])
            );
        end
    end

    pk_legal u_legal (
        .lane_sel (lane_sel),
        .op_sel   (op_sel),
        .legal    (legal)
    );

    // Select the bank matching the requested lane size.
    assign res_sel = res_w[lane_sel];

    // Result stage: capture on valid input, zero and flag an illegal pairing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_illegal <= in_valid && !legal;
            if (in_valid) begin
                out_data <= legal ? res_sel : '0;
            end
        end
    end

endmodule

// File: rtl/pk_addsub_alu_chk.sv
// Module: property checker for pk_addsub_alu, attached by bind below.
// Watches ports only. Assumes the codes from pk_alu_pkg.
module pk_addsub_alu_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        lane_sel,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_illegal
);
    localparam int NBYTES = DATA_W / 8;

    logic [NBYTES-1:0] byte_ok;

    // Each byte of the output is a whole-lane mask value.
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign byte_ok[i] = (out_data[i*8 +: 8] == 8'h00) || (out_data[i*8 +: 8] == 8'hFF);
    end

    p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_valid && out_data == '0));

    p_dword_sat_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && lane_sel == 2'd3 && op_sel >= 4'd2) |-> out_illegal);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_data) && !out_illegal));

    p_eq_self_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && op_sel == 4'd7 && lane_sel != 2'd3 && opnd_a == opnd_b)
        |-> (out_data == {DATA_W{1'b1}}));

    p_gt_byte_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && op_sel == 4'd8 && lane_sel == 2'd0) |-> (&byte_ok));

endmodule

bind pk_addsub_alu pk_addsub_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .lane_sel    (lane_sel),
    .op_sel      (op_sel),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_illegal (out_illegal)
);

// File: tb/sim_pk_addsub_alu.sv
// Bench: walks a table of vectors through pk_addsub_alu, then runs directed
// tests for reset, idle hold and latency. 50 MHz clock.
module sim_pk_addsub_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  lane_sel = '0;
    logic [3:0]  op_sel = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_illegal;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pk_addsub_alu #(.DATA_W(64)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .lane_sel    (lane_sel),
        .op_sel      (op_sel),
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_illegal (out_illegal)
    );

    // Vector fields: lane[198:197] op[196:193] a[192:129] b[128:65] exp[64:1] ill[0]
    localparam int NV = 18;
    localparam logic [198:0] VEC [NV] = '{
        {2'd0, 4'd0, 64'h01FF_7F80_0010_20FF, 64'h0101_0180_00F0_E001, 64'h0200_8000_0000_0000, 1'b0},
        {2'd1, 4'd0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 64'h0000_0000_0000_0000, 1'b0},
        {2'd2, 4'd0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 64'h0001_0000_0001_0000, 1'b0},
        {2'd3, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 1'b0},
        {2'd0, 4'd1, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_00FE, 1'b0},
        {2'd3, 4'd1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        {2'd0, 4'd2, 64'h7F80_0170_0000_0000, 64'h0180_0120_0000_0000, 64'h7F80_027F_0000_0000, 1'b0},
        {2'd1, 4'd3, 64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0007_8000, 64'h8000_7FFF_FFFE_7FFF, 1'b0},
        {2'd0, 4'd4, 64'hFF80_1000_0000_0000, 64'h0180_2000_0000_0000, 64'hFFFF_3000_0000_0000, 1'b0},
        {2'd1, 4'd5, 64'h0005_0010_0000_FFFF, 64'h0007_0001_0001_FFFF, 64'h0000_000F_0000_0000, 1'b0},
        {2'd0, 4'd6, 64'hFF00_0102_0000_0000, 64'hFF01_0203_0000_0000, 64'hFF01_0203_0000_0000, 1'b0},
        {2'd1, 4'd6, 64'hFFFF_0001_8000_0000, 64'hFFFE_0002_8000_0001, 64'hFFFF_0002_8000_0001, 1'b0},
        {2'd0, 4'd7, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, 64'hFFFF_00FF_FF00_FFFF, 1'b0},
        {2'd2, 4'd8, 64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 1'b0},
        {2'd1, 4'd8, 64'h8000_0001_0005_7FFF, 64'h7FFF_0001_0004_8000, 64'h0000_0000_FFFF_FFFF, 1'b0},
        {2'd3, 4'd2, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 1'b1},
        {2'd2, 4'd6, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0000, 1'b1},
        {2'd0, 4'd9, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0000, 1'b1}
    };

    // Map an operation code to the requirement it exercises.
    function automatic string req_of(input logic [3:0] op, input logic ill);
        if (ill) return "R9";
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2, 4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Compare one observed value with its expected value and count the check.
    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset clears outputs, even with a valid request at the edge.
        @(negedge clk);
        lane_sel = 2'd0; op_sel = 4'd0; in_valid = 1'b1;
        opnd_a = 64'h1111_1111_1111_1111; opnd_b = 64'h2222_2222_2222_2222;
        @(negedge clk);
        chk("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
        chk("R1", "reset out_data", out_data, 64'd0);
        chk("R1", "reset out_illegal", {63'd0, out_illegal}, 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, sample after the next rising edge.
        for (int i = 0; i < NV; i++) begin
            lane_sel = VEC[i][198:197];
            op_sel   = VEC[i][196:193];
            opnd_a   = VEC[i][192:129];
            opnd_b   = VEC[i][128:65];
            in_valid = 1'b1;
            @(negedge clk);
            chk(req_of(VEC[i][196:193], VEC[i][0]), $sformatf("vec %0d data", i), out_data, VEC[i][64:1]);
            chk(req_of(VEC[i][196:193], VEC[i][0]), $sformatf("vec %0d illegal", i), {63'd0, out_illegal}, {63'd0, VEC[i][0]});
            chk("R1", $sformatf("vec %0d valid", i), {63'd0, out_valid}, 64'd1);
        end

        // R10: idle cycle after an illegal result; data holds, flag drops.
        in_valid = 1'b0; lane_sel = 2'd0; op_sel = 4'd0;
        opnd_a = 64'h0101_0101_0101_0101; opnd_b = 64'h0101_0101_0101_0101;
        @(negedge clk);
        chk("R10", "idle illegal low", {63'd0, out_illegal}, 64'd0);
        chk("R1", "idle valid low", {63'd0, out_valid}, 64'd0);
        chk("R10", "idle data held", out_data, 64'd0);

        // R10: a legal result survives later idle cycles with changing inputs.
        in_valid = 1'b1; lane_sel = 2'd2; op_sel = 4'd7;
        opnd_a = 64'h1234_5678_9ABC_DEF0; opnd_b = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        chk("R7", "word eq equal", out_data, 64'hFFFF_FFFF_FFFF_FFFF);
        in_valid = 1'b0; op_sel = 4'd1; opnd_b = 64'h0;
        @(negedge clk);
        op_sel = 4'd15;
        @(negedge clk);
        chk("R10", "hold after idle", out_data, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R10", "illegal code ignored when idle", {63'd0, out_illegal}, 64'd0);

        // R9: compare at the 64-bit lane size is illegal.
        in_valid = 1'b1; lane_sel = 2'd3; op_sel = 4'd7;
        @(negedge clk);
        chk("R9", "dword eq data", out_data, 64'd0);
        chk("R9", "dword eq flag", {63'd0, out_illegal}, 64'd1);

        // R1: reset in mid-stream clears a held result.
        lane_sel = 2'd0; op_sel = 4'd0; opnd_a = 64'h5; opnd_b = 64'h6;
        @(negedge clk);
        chk("R2", "byte add before reset", out_data, 64'h0000_0000_0000_000B);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid reset data", out_data, 64'd0);
        chk("R1", "mid reset valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule